// File: doc/BRIEF.md
# Phase Accumulator Square-Wave Generator

This block is a numerically controlled oscillator that turns a fast system clock into a slow square wave, for instance an audible tone driven onto a speaker pin. A tuning word sets the output rate. On every enabled clock the block adds the tuning word to a wide phase register and keeps only the low bits of the sum. The top bit of that register is the square wave. The output frequency is therefore fc·n/2^k, where fc is the clock rate, n is the tuning word and k is the register width. The frequency step is fc/2^k.

With the default width of 32 bits and a 200 MHz clock, a tuning word of 8590 gives a tone of roughly 400.003 Hz. The price of the fine resolution is edge placement. Each output edge can sit up to half a system clock period away from where an ideal waveform would put it. Only the average rate is exact.

The tuning word enters through a load strobe and is held in an internal register. A new word changes the rate from the next step onward and leaves the current phase untouched. An enable input freezes the oscillator. A one-cycle tick marks each rising edge of the wave.

Top module: `nco_square_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase register, the held tuning word and the edge history are all cleared. After that edge `wave_out` and `rise_tick` are both 0, and the held tuning word stays 0 until a load.
- R2: On each rising clock edge with `en` high, the phase register takes the value (phase + held tuning word) mod 2^ACC_W. `wave_out` is bit ACC_W-1 of the phase register.
- R3: The held tuning word takes the value of `tune_word` only at an edge where `tune_load` is high. At any other edge a change on `tune_word` has no effect on the held word or on `wave_out`.
- R4: A load does not move the phase. At an edge where `tune_load` and `en` are both high, the step uses the previously held word. The newly loaded word is used from the next enabled edge on.
- R5: At an edge where `en` is low, the phase register keeps its value and `wave_out` does not change.
- R6: `rise_tick` is high for exactly one clock: the first cycle in which `wave_out` is 1 after a cycle in which it was 0.
- R7: A held tuning word of 0 keeps `wave_out` constant. A held tuning word of 2^(ACC_W-1) inverts `wave_out` at every enabled edge.
- R8: Take a tuning word n with 0 < n < 2^(ACC_W-1), and let g = gcd(n, 2^ACC_W). Over any run of 2^ACC_W/g consecutive enabled clocks, exactly n/g rising ticks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the phase when high; holds it when low |
| tune_load | input | 1 | Strobe that captures `tune_word` into the held tuning register |
| tune_word | input | ACC_W | Phase increment per enabled clock |
| wave_out | output | 1 | Square wave, the top bit of the phase register |
| rise_tick | output | 1 | One-clock pulse on each rising edge of `wave_out` |

## Verification
Two things can happen in the same cycle: a tuning-word load and a phase step. A load can also arrive while the oscillator is frozen. The bench provokes both by asserting `tune_load` together with `en` high, and again with `en` low, in directed steps and in random ones. It judges the result against a bench model in which the step at the load edge still uses the old word and the new word takes effect only from the following enabled edge. Any premature or missing use of the new word shows up as a `wave_out` or `rise_tick` mismatch a few cycles later, and the gcd-based edge count confirms the long-run rate.

// File: rtl/nco_pkg.sv
// Package: shared constants and helpers for the square-wave oscillator.
// Assumes: nothing beyond standard SystemVerilog.
package nco_pkg;

    // Default phase register width; sets resolution fc/2^width.
    localparam int unsigned NCO_DEF_ACC_W = 32;

    // Rising-level test used by the edge detector.
    function automatic logic nco_is_rise(input logic now_lvl, input logic old_lvl);
        return now_lvl & ~old_lvl;
    endfunction

endpackage

// File: rtl/nco_tune_reg.sv
// Module: holds the phase increment.
// What it does: captures the incoming tuning word only on a load strobe.
// Assumes: synchronous active-low reset; the word is stable when loaded.
module nco_tune_reg #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] word_in,
    output logic [ACC_W-1:0] word_q
);

    // Capture the word on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
// Module: modulo-2^ACC_W phase accumulator.
// What it does: adds the step to the phase on enabled edges; the carry out is dropped.
// Assumes: the step is already registered, so a load never alters the step in flight.
module nco_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase_q
);

    logic [ACC_W-1:0] phase_nxt;

    // Wrapping sum: the width truncates the carry out.
    always_comb begin
        phase_nxt = phase_q + step;
    end

    // Advance the phase when enabled; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_nxt;
        end
    end

endmodule

// File: rtl/nco_rise_detect.sv
// Module: rising-edge pulse generator.
// What it does: pulses for one clock when the level goes from 0 to 1.
// Assumes: the level comes from a register in the same clock domain.
module nco_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);

    import nco_pkg::*;

    logic lvl_d;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= 1'b0;
        end else begin
            lvl_d <= lvl;
        end
    end

    // Pulse in the first cycle of a high level.
    always_comb begin
        pulse = nco_is_rise(lvl, lvl_d);
    end

endmodule

// File: rtl/nco_square_top.sv
// Module: numerically controlled square-wave oscillator (top).
// What it does: output rate is fc*n/2^ACC_W; the wave is the phase MSB, and
//   a tick marks each rising wave edge.
// Assumes: ACC_W >= 2; edges carry up to +/- half a clock of jitter.
module nco_square_top #(
    parameter int unsigned ACC_W = nco_pkg::NCO_DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tune_load,
    input  logic [ACC_W-1:0] tune_word,
    output logic             wave_out,
    output logic             rise_tick
);

    localparam int unsigned MSB = ACC_W - 1;

    logic [ACC_W-1:0] tune_q;
    logic [ACC_W-1:0] acc_q;

    nco_tune_reg #(.ACC_W(ACC_W)) u_tune (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tune_load),
        .word_in (tune_word),
        .word_q  (tune_q)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .step    (tune_q),
        .phase_q (acc_q)
    );

    // Square wave is the top phase bit.
    always_comb begin
        wave_out = acc_q[MSB];
    end

    nco_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (wave_out),
        .pulse (rise_tick)
    );

endmodule

// File: rtl/nco_square_chk.sv
// Module: assertion checker for nco_square_top, attached by bind.
// What it does: checks stepping, loading, holding and tick rules over time.
// Assumes: it sees the held word and the phase of the top module.
module nco_square_chk #(
    parameter int unsigned ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tune_load,
    input logic [ACC_W-1:0] tune_word,
    input logic [ACC_W-1:0] tune_q,
    input logic [ACC_W-1:0] acc_q,
    input logic             wave_out,
    input logic             rise_tick
);

    localparam logic [ACC_W-1:0] HALF_W = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] sum_w;
    assign sum_w = acc_q + tune_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> acc_q == $past(sum_w)); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        tune_load |=> tune_q == $past(tune_word)); // R3
    AST_NO_LOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tune_load |=> $stable(tune_q)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q) && $stable(wave_out)); // R5
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> !rise_tick); // R6
    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave_out) |-> rise_tick); // R6
    AST_ZERO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_q == '0) |=> $stable(wave_out)); // R7
    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tune_q == HALF_W) |=> wave_out != $past(wave_out)); // R7

endmodule

bind nco_square_top nco_square_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tune_load (tune_load),
    .tune_word (tune_word),
    .tune_q    (tune_q),
    .acc_q     (acc_q),
    .wave_out  (wave_out),
    .rise_tick (rise_tick)
);

// File: tb/sim_nco_square_top.sv
// Bench: random and directed stimulus against a bench-side phase model.
module sim_nco_square_top;

    localparam int unsigned W = 12;
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         tune_load = 1'b0;
    logic [W-1:0] tune_word = '0;
    logic         wave_out;
    logic         rise_tick;

    int pass_cnt = 0;
    int fail_cnt = 0;
    int tick_cnt = 0;
    logic [W-1:0] m_acc = '0;
    logic [W-1:0] m_tune = '0;

    always #2.5 clk = ~clk;

    nco_square_top #(.ACC_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tune_load(tune_load),
        .tune_word(tune_word), .wave_out(wave_out), .rise_tick(rise_tick)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint gcd_pow2(input longint n);
        longint g = 1;
        for (int i = 0; i < W; i++) begin
            if ((n % (g * 2)) == 0) g = g * 2;
        end
        return g;
    endfunction

    // One clock: apply inputs, advance the model, compare outputs.
    task automatic cyc(input logic e, input logic ld, input logic [W-1:0] wd, input string req);
        logic old_msb;
        @(negedge clk);
        en = e; tune_load = ld; tune_word = wd;
        @(posedge clk);
        old_msb = m_acc[W-1];
        if (e) m_acc = m_acc + m_tune;   // step uses the word held before this edge (R4)
        if (ld) m_tune = wd;
        #1;
        check(wave_out == m_acc[W-1], {req, " wave"}, wave_out, m_acc[W-1]);
        check(rise_tick == (m_acc[W-1] & ~old_msb), "R6 tick", rise_tick, m_acc[W-1] & ~old_msb);
        if (rise_tick) tick_cnt++;
    endtask

    initial begin
        #(200000 * 5);
        fail_cnt++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: loads and enables during reset are cleared
        rst_n = 1'b0; en = 1'b1; tune_load = 1'b1; tune_word = HALF;
        repeat (4) @(posedge clk);
        #1;
        check(wave_out == 1'b0, "R1 wave in reset", wave_out, 0);
        check(rise_tick == 1'b0, "R1 tick in reset", rise_tick, 0);
        @(negedge clk); rst_n = 1'b1; tune_load = 1'b0;
        // R1/R7: held word is 0 after reset, so the wave stays low
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, HALF, "R1 R7 zero word");
        // R7: half-range word toggles every clock
        cyc(1'b1, 1'b1, HALF, "R4 load");
        for (int i = 0; i < 10; i++) begin
            logic prev;
            prev = wave_out;
            cyc(1'b1, 1'b0, '0, "R7 half");
            check(wave_out != prev, "R7 toggle", wave_out, ~prev);
        end
        // R2 and R4: load with enable in the same cycle, directed
        cyc(1'b1, 1'b1, 12'd300, "R4 load with step");
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, '0, "R2 step");
        cyc(1'b1, 1'b1, 12'd1500, "R4 reload");
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 12'd7, "R2 step");
        // R3: word changes without a strobe are ignored
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, W'($urandom), "R3 no load");
        // R5: frozen while disabled, even with loads arriving
        for (int i = 0; i < 15; i++) begin
            logic prev;
            prev = wave_out;
            cyc(1'b0, i[0], W'($urandom), "R5 hold");
            check(wave_out == prev, "R5 frozen", wave_out, prev);
        end
        // R2 R3 R4 R5: constrained random mix
        for (int i = 0; i < 400; i++)
            cyc(($urandom % 4) != 0, ($urandom % 16) == 0, W'($urandom), "R2 random");
        // R8: count rising ticks over one full phase cycle
        for (int t = 0; t < 5; t++) begin
            longint n, g;
            n = (t == 0) ? 1 : (t == 1) ? 1024 + 512 : 1 + ($urandom % (2 ** (W - 1) - 1));
            g = gcd_pow2(n);
            cyc(1'b1, 1'b1, W'(n), "R4 load");
            cyc(1'b1, 1'b0, '0, "R2 settle");
            tick_cnt = 0;
            for (longint i = 0; i < (2 ** W) / g; i++) cyc(1'b1, 1'b0, '0, "R2 run");
            check(tick_cnt == n / g, "R8 edge count", tick_cnt, n / g);
        end
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

endmodule